// File: doc/BRIEF.md
# Single-Accumulator Datapath Core

This block is an 8-bit execution core built around one accumulator. Each clock it takes a fully decoded instruction word and completes that instruction in the same cycle. The ALU has three units: an adder/subtractor, a logic unit and a one-bit shifter. All three work on the same operands every cycle, and a three-bit opcode picks which result is kept. The first operand is always the accumulator. The second operand is either the external data input or one of four working-register slots. The top slot is a fixed constant of one, so incrementing and decrementing need no dedicated instruction.

A program sequencer outside the block supplies one instruction per clock. Bit flags in the instruction choose the effects of that cycle: write the ALU result back to the accumulator, store the accumulator into the selected slot, copy the accumulator to the output register, and take the external input as the operand. The output register is the only visible result. It keeps its value until an instruction asks for a new copy.

Top module: `acc_core`

## Requirements
- R1: Synchronous reset sets the accumulator, working registers 0 to 2 and the output register to zero.
- R2: The 9-bit instruction word is laid out as follows. Bits [2:0] are the ALU opcode. Bit 3 selects the external input as the operand. Bit 4 copies the accumulator to the output. Bit 5 stores the accumulator into the selected slot. Bit 6 writes the ALU result to the accumulator. Bits [8:7] select the slot.
- R3: Opcode 000 adds the operand to the accumulator, modulo 256.
- R4: Opcode 001 subtracts the operand from the accumulator, modulo 256 (3 minus 5 gives 254).
- R5: Opcodes 010, 011 and 100 give the bitwise AND, OR and XOR of the accumulator and the operand. Opcode 101 gives the bitwise inverse of the operand.
- R6: Opcode 110 shifts the accumulator left by one bit and opcode 111 shifts it right by one bit. In both cases the vacated bit is filled with zero.
- R7: When bit 3 is set, the operand is the data input, whatever the slot selection. When bit 3 is clear, the operand is the selected slot.
- R8: Slot 3 always reads as 1. A store addressed to slot 3 has no effect.
- R9: With bit 5 set, the selected slot (0 to 2) takes the accumulator value from before the clock edge.
- R10: With bit 4 set, the output register takes the accumulator value from before the edge. With bit 4 clear, the output register holds its value.
- R11: With bit 6 clear, the accumulator is unchanged.
- R12: All effects of an instruction take place on a single clock edge, and each effect uses the state from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 9 | Decoded instruction word |
| din_i | input | 8 | External data operand |
| dout_o | output | 8 | Output register |

## Verification
The adder is driven with operands that wrap past 255 and with small operands that do not, so a carry lost between bits shows up. Subtraction is driven with a larger operand, which needs the borrow to reach the top bit, and with the constant slot, which separates a correct decrement from an inverted operand that is missing its carry-in. Each logic opcode uses the same pair of operands, chosen so that every opcode gives a different result. The shifts use a pattern with both end bits set, so both the zero fill and the bit that falls off are visible. Instructions that combine several effects in one cycle check that stores and output copies take the accumulator value from before the edge, not the new one.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100,
    OP_NOT = 3'b101,
    OP_SHL = 3'b110,
    OP_SHR = 3'b111
  } alu_op_e;

  localparam int OP_LSB  = 0;
  localparam int EXT_BIT = 3;
  localparam int OUT_BIT = 4;
  localparam int STO_BIT = 5;
  localparam int WR_BIT  = 6;
  localparam int SEL_LSB = 7;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] arith_o,
  output logic [DATA_W-1:0] logic_o,
  output logic [DATA_W-1:0] shift_o,
  output logic [DATA_W-1:0] res_o
);
  // Ripple-carry adder/subtractor: subtract inverts b and forces carry-in.
  function automatic logic [DATA_W-1:0] ripple_addsub(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input logic sub);
    logic              cy;
    logic [DATA_W-1:0] bx;
    logic [DATA_W-1:0] s;
    cy = sub;
    bx = sub ? ~b : b;
    for (int i = 0; i < DATA_W; i++) begin
      s[i] = a[i] ^ bx[i] ^ cy;
      cy   = (a[i] & bx[i]) | (cy & (a[i] ^ bx[i]));
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] shift_one(
    input logic [DATA_W-1:0] a, input logic right);
    return right ? {1'b0, a[DATA_W-1:1]} : {a[DATA_W-2:0], 1'b0};
  endfunction

  // All three units evaluate every cycle.
  always_comb begin
    arith_o = ripple_addsub(a_i, b_i, op_i == OP_SUB);
    shift_o = shift_one(a_i, op_i == OP_SHR);
    unique case (op_i)
      OP_AND:  logic_o = a_i & b_i;
      OP_OR:   logic_o = a_i | b_i;
      OP_XOR:  logic_o = a_i ^ b_i;
      default: logic_o = ~b_i;
    endcase
  end

  // Final select.
  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB: res_o = arith_o;
      OP_SHL, OP_SHR: res_o = shift_o;
      default:        res_o = logic_o;
    endcase
  end
endmodule

// File: rtl/acc_slots.sv
module acc_slots #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  localparam int NSLOT = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] slot_w [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g == NSLOT - 1) begin : g_const
      // Top slot is a fixed one; it has no storage, so stores vanish.
      assign slot_w[g] = DATA_W'(1);
    end else begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (wr_i && sel_i == SEL_W'(g)) q <= wdata_i;
      end
      assign slot_w[g] = q;
    end
  end

  assign rdata_o = slot_w[sel_i];
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  localparam int INSTR_W = SEL_LSB + SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  din_i,
  output logic [DATA_W-1:0]  dout_o
);
  // Decoded fields, named for the checker.
  alu_op_e           op_w;
  logic              use_ext_w;
  logic              out_we_w;
  logic              store_w;
  logic              acc_we_w;
  logic [SEL_W-1:0]  sel_w;

  assign op_w      = alu_op_e'(instr_i[OP_LSB +: 3]);
  assign use_ext_w = instr_i[EXT_BIT];
  assign out_we_w  = instr_i[OUT_BIT];
  assign store_w   = instr_i[STO_BIT];
  assign acc_we_w  = instr_i[WR_BIT];
  assign sel_w     = instr_i[SEL_LSB +: SEL_W];

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] slot_rd_w;
  logic [DATA_W-1:0] operand_w;
  logic [DATA_W-1:0] arith_w;
  logic [DATA_W-1:0] logic_w;
  logic [DATA_W-1:0] shift_w;
  logic [DATA_W-1:0] alu_res_w;

  acc_slots #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_slots (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (store_w),
    .sel_i  (sel_w),
    .wdata_i(acc_q),
    .rdata_o(slot_rd_w)
  );

  assign operand_w = use_ext_w ? din_i : slot_rd_w;

  acc_alu #(.DATA_W(DATA_W)) i_alu (
    .a_i    (acc_q),
    .b_i    (operand_w),
    .op_i   (op_w),
    .arith_o(arith_w),
    .logic_o(logic_w),
    .shift_o(shift_w),
    .res_o  (alu_res_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      out_q <= '0;
    end else begin
      if (acc_we_w) acc_q <= alu_res_w;
      if (out_we_w) out_q <= acc_q;
    end
  end

  assign dout_o = out_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input alu_op_e           op,
  input logic              use_ext,
  input logic              out_we,
  input logic              acc_we,
  input logic [SEL_W-1:0]  sel,
  input logic [DATA_W-1:0] acc,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] alu_res,
  input logic [DATA_W-1:0] dout
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (acc == '0 && dout == '0));

  p_sub_result_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB) |-> alu_res == acc - operand);

  p_add_result_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |-> alu_res == acc + operand);

  p_const_slot_r8: assert property (@(posedge clk) disable iff (rst)
    (!use_ext && (&sel)) |-> operand == DATA_W'(1));

  p_out_copy_r10: assert property (@(posedge clk) disable iff (rst)
    out_we |=> dout == $past(acc));

  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !out_we |=> $stable(dout));

  p_acc_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !acc_we |=> $stable(acc));

  p_acc_write_r12: assert property (@(posedge clk) disable iff (rst)
    acc_we |=> acc == $past(alu_res));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .op     (op_w),
  .use_ext(use_ext_w),
  .out_we (out_we_w),
  .acc_we (acc_we_w),
  .sel    (sel_w),
  .acc    (acc_q),
  .operand(operand_w),
  .alu_res(alu_res_w),
  .dout   (dout_o)
);

// File: tb/test_acc_core.sv
module test_acc_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] instr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model state.
  logic [7:0] m_a, m_out;
  logic [7:0] m_c [3];

  always #2.5 clk = ~clk;

  acc_core i_acc_core (.clk(clk), .rst(rst), .instr_i(instr), .din_i(din), .dout_o(dout));

  function automatic logic [8:0] mk(input int sel, input bit wr, input bit sto,
                                    input bit outc, input bit ext, input logic [2:0] op);
    return {sel[1:0], wr, sto, outc, ext, op};
  endfunction

  function automatic logic [7:0] ref_alu(input logic [2:0] op, input logic [7:0] a,
                                         input logic [7:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return ~b;
      3'd6: return a << 1;
      default: return a >> 1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: dout=%0d expected=%0d", req, dout, exp);
    end
  endtask

  // Drive at negedge, commit at posedge, update model from pre-edge state.
  task automatic exec(input logic [8:0] ins, input logic [7:0] d);
    logic [7:0] b, na, nout;
    instr = ins;
    din = d;
    b = ins[3] ? d : ((ins[8:7] == 2'd3) ? 8'd1 : m_c[ins[8:7]]);
    na = ins[6] ? ref_alu(ins[2:0], m_a, b) : m_a;
    nout = ins[4] ? m_a : m_out;
    if (ins[5] && ins[8:7] != 2'd3) m_c[ins[8:7]] = m_a;
    m_a = na;
    m_out = nout;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic show(input string req);
    exec(mk(0, 0, 0, 1, 0, 3'd0), 8'd0);
    chk(req, m_out);
  endtask

  task automatic load(input logic [7:0] v);
    exec(mk(0, 1, 0, 0, 1, 3'd2), 8'd0);
    exec(mk(0, 1, 0, 0, 1, 3'd3), v);
  endtask

  task automatic t_reset();
    chk("R1 out", 8'd0);
    show("R1 acc");
    for (int r = 0; r < 3; r++) begin
      exec(mk(r, 1, 0, 0, 0, 3'd0), 8'd0);
      show("R1 slot");
    end
  endtask

  task automatic t_add();
    load(8'd200); exec(mk(0, 1, 0, 0, 1, 3'd0), 8'd100); show("R3 wrap");
    if (m_out != 8'd44) errors++;
    load(8'd5); exec(mk(0, 1, 0, 0, 1, 3'd0), 8'd3); show("R3 small");
  endtask

  task automatic t_sub();
    load(8'd3); exec(mk(0, 1, 0, 0, 1, 3'd1), 8'd5); show("R4 borrow");
    if (m_out != 8'd254) errors++;
    load(8'd100); exec(mk(3, 1, 0, 0, 0, 3'd1), 8'd0); show("R4 R8 decrement");
  endtask

  task automatic t_logic();
    for (int op = 2; op < 6; op++) begin
      load(8'hCA);
      exec(mk(0, 1, 0, 0, 1, 3'(op)), 8'h3C);
      show("R5 logic op");
    end
  endtask

  task automatic t_shift();
    load(8'h81); exec(mk(0, 1, 0, 0, 0, 3'd6), 8'd0); show("R6 left");
    load(8'h81); exec(mk(0, 1, 0, 0, 0, 3'd7), 8'd0); show("R6 right");
  endtask

  task automatic t_store();
    load(8'h11);
    exec(mk(1, 1, 1, 0, 1, 3'd0), 8'd1);   // store old A and add in one cycle
    load(8'd0); exec(mk(1, 1, 0, 0, 0, 3'd0), 8'd0); show("R9 R12 store old A");
    load(8'd7); exec(mk(3, 0, 1, 0, 0, 3'd0), 8'd0);
    load(8'd0); exec(mk(3, 1, 0, 0, 0, 3'd0), 8'd0); show("R8 const write ignored");
  endtask

  task automatic t_operand();
    load(8'h20); exec(mk(2, 0, 1, 0, 0, 3'd0), 8'd0);
    load(8'h01); exec(mk(2, 1, 0, 0, 1, 3'd0), 8'h05); show("R7 external wins");
    exec(mk(2, 1, 0, 0, 0, 3'd0), 8'h05); show("R7 slot operand");
  endtask

  task automatic t_out();
    load(8'd9); show("R10 copy");
    load(8'd77); chk("R10 hold", m_out);
    exec(mk(0, 1, 0, 1, 1, 3'd0), 8'd3); chk("R12 old A to out", m_out);
    exec(mk(0, 0, 0, 0, 1, 3'd0), 8'd50); show("R11 no write");
    exec(mk(0, 1, 0, 0, 1, 3'd4), 8'hFF); show("R2 field decode");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_a = '0; m_out = '0;
    for (int i = 0; i < 3; i++) m_c[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_store();
    t_operand();
    t_out();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule